// File: doc/BRIEF.md
# Three-Stage Pipeline Branch Controller

This block sequences an in-order pipeline with three stages: fetch, decode and execute. It drives the instruction-memory address and captures the instruction word returned in the same cycle. It moves each instruction through decode into execute and reports every instruction that completes on a retire trace, together with the register it writes. Branches are resolved only in execute, using a condition flag that the datapath supplies in that cycle.

Each branch word carries a mode bit. A delayed branch lets the two instructions behind it complete whether or not it is taken. A squashing branch discards them when it is taken. Load-multiple words occupy execute for one cycle per listed register and hold the younger instructions in place meanwhile. An instruction that reads the last register of such a list gets one extra bubble. A branch found in the delay slot of a delayed branch is flagged and has no effect.

Top module: `branch_pipe_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both stage valid bits clear. After that edge `imem_addr` is 0 and `ret_valid`, `wr_en`, `redirect` and `seq_err` are 0.
- R2: With no stalls, the fetch address rises by one every cycle and one instruction retires per cycle. The word fetched in the first cycle after reset retires in the third cycle, so N instructions take 3 + (N-1) cycles.
- R3: A taken branch with mode bit 0 raises `redirect` in its retire cycle. The next fetch address is its target, and the two younger words already fetched neither retire nor write.
- R4: A branch with mode bit 1 is followed on the retire trace by the two words at the next two addresses, taken or not. When taken, it raises `redirect` and fetch continues at its target after those two.
- R5: A branch whose condition flag is 0, in either mode, raises no `redirect`, inserts no bubble and leaves fetch sequential.
- R6: A load-multiple spends one execute cycle per set bit of its list, lowest register first. It asserts `wr_en` with that register in each of those cycles and retires once, in the last one, while fetch and decode hold. An empty list takes one cycle and writes nothing.
- R7: If the word in decode reads (rs1 or rs2) the highest register of a load-multiple that is in its last execute cycle, exactly one bubble is placed before that word executes. A read of any other register adds no bubble.
- R8: A branch that executes as one of the two slots after a delayed branch pulses `seq_err`. It still retires, but it never raises `redirect`, so the first branch's target stays in force.
- R9: Word encoding, 14 bits. Bits 13:12 are the operation: 00 compute, 01 branch, 10 load-multiple, 11 no-op. Bit 11 is the branch mode (1 delayed). Bits 10:8 hold the compute destination, 6:4 source 1 and 2:0 source 2. Bits 7:0 hold the branch target or the load list, where bit i stands for register i. Compute words write their destination at retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | ADDR_W | Address of the word being fetched |
| imem_data | input | 14 | Instruction word read at `imem_addr` in the same cycle |
| br_cond | input | 1 | Condition flag for the branch now in execute |
| ret_valid | output | 1 | An instruction completes this cycle |
| ret_pc | output | ADDR_W | Address of the completing instruction |
| wr_en | output | 1 | A register is written this cycle |
| wr_reg | output | 3 | Index of the register written |
| redirect | output | 1 | A taken, legal branch changes the fetch stream |
| seq_err | output | 1 | A branch was met inside a delay slot |

## Verification
The main program puts a taken squashing branch in front of two compute words. A controller that failed to squash them would show addresses 3 and 4 on the retire trace before the target. A load-multiple follows, and its successor reads the last listed register; a controller without the interlock would retire that successor one cycle early with no bubble. A delayed branch then carries a second branch in its second slot. A design that honoured the inner branch would jump to 30 rather than 20, and one that miscounted slots would either miss `seq_err` or flag the wrong word. Directed runs cover a delayed branch that is not taken, an empty load list, a successor that reads a non-final list register and must not stall, and reset applied in the middle of a run.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int WORD_W = 14;
    localparam int NREG   = 8;
    localparam int REG_W  = $clog2(NREG);
    localparam int PAY_W  = 8;

    typedef enum logic [1:0] {
        OP_ALU = 2'b00,
        OP_BR  = 2'b01,
        OP_LDM = 2'b10,
        OP_NOP = 2'b11
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             delayed;
        logic [REG_W-1:0] rd;
        logic [PAY_W-1:0] payload;
    } word_t;

    function automatic word_t unpack_word(input logic [WORD_W-1:0] w);
        word_t r;
        r.op      = op_e'(w[13:12]);
        r.delayed = w[11];
        r.rd      = w[10:8];
        r.payload = w[7:0];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] lowest_set(input logic [NREG-1:0] m);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (m[i]) r = REG_W'(i);
        end
        return r;
    endfunction

    function automatic logic [REG_W-1:0] highest_set(input logic [NREG-1:0] m);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < NREG; i++) begin
            if (m[i]) r = REG_W'(i);
        end
        return r;
    endfunction

    function automatic logic at_most_one(input logic [NREG-1:0] m);
        return (m & (m - 1'b1)) == '0;
    endfunction

endpackage

// File: rtl/brc_fetch.sv
module brc_fetch #(
    parameter int ADDR_W = 8,
    parameter int TGT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              redirect,
    input  logic [TGT_W-1:0]  target,
    output logic [ADDR_W-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (redirect) begin
            pc <= ADDR_W'(target);
        end else if (!hold) begin
            pc <= pc + 1'b1;
        end
    end

endmodule

// File: rtl/brc_ldm_seq.sv
module brc_ldm_seq
    import brc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [NREG-1:0]  rlist,
    output logic             busy,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_reg,
    output logic [REG_W-1:0] last_reg,
    output logic             final_cyc
);

    logic [NREG-1:0] done_q;
    logic [NREG-1:0] remain;

    assign remain    = rlist & ~done_q;
    assign busy      = active && !at_most_one(remain);
    assign wr_en     = active && (remain != '0);
    assign wr_reg    = lowest_set(remain);
    assign last_reg  = highest_set(rlist);
    assign final_cyc = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            done_q <= '0;
        end else begin
            done_q <= done_q | (NREG'(1) << wr_reg);
        end
    end

    // R6: a multi-cycle load keeps writing in the following cycle
    p_ldm_progress_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> (active && wr_en));

endmodule

// File: rtl/brc_branch_ctl.sv
module brc_branch_ctl (
    input  logic clk,
    input  logic rst,
    input  logic e_valid,
    input  logic e_is_br,
    input  logic e_delayed,
    input  logic e_busy,
    input  logic cond,
    output logic redirect,
    output logic squash,
    output logic seq_err
);

    logic [1:0] slots_q;
    logic       in_slot;
    logic       legal_br;

    assign in_slot  = (slots_q != 2'd0);
    assign legal_br = e_valid && e_is_br && !in_slot;
    assign redirect = legal_br && cond;
    assign squash   = redirect && !e_delayed;
    assign seq_err  = e_valid && e_is_br && in_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= 2'd0;
        end else if (legal_br && e_delayed) begin
            slots_q <= 2'd2;
        end else if (in_slot && e_valid && !e_busy) begin
            slots_q <= slots_q - 2'd1;
        end
    end

    // R8: two slot instructions follow a delayed branch, then the window closes
    p_slot_window_r8: assert property (@(posedge clk) disable iff (rst)
        (slots_q == 2'd1 && e_valid && !e_busy) |=> !in_slot);

endmodule

// File: rtl/branch_pipe_ctrl.sv
module branch_pipe_ctrl
    import brc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_data,
    input  logic              br_cond,
    output logic              ret_valid,
    output logic [ADDR_W-1:0] ret_pc,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_reg,
    output logic              redirect,
    output logic              seq_err
);

    logic              d_valid, e_valid;
    logic [WORD_W-1:0] d_word;
    logic [ADDR_W-1:0] d_pc, e_pc;
    word_t             e_q;
    word_t             d_f;

    logic              e_busy, ldm_we, ldm_final, squash, dep_stall, hold_front;
    logic [REG_W-1:0]  ldm_reg, ldm_last;

    assign d_f = unpack_word(d_word);

    brc_fetch #(.ADDR_W(ADDR_W), .TGT_W(PAY_W)) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold_front),
        .redirect (redirect),
        .target   (e_q.payload),
        .pc       (imem_addr)
    );

    brc_ldm_seq u_ldm (
        .clk       (clk),
        .rst       (rst),
        .active    (e_valid && e_q.op == OP_LDM),
        .rlist     (e_q.payload),
        .busy      (e_busy),
        .wr_en     (ldm_we),
        .wr_reg    (ldm_reg),
        .last_reg  (ldm_last),
        .final_cyc (ldm_final)
    );

    brc_branch_ctl u_br (
        .clk       (clk),
        .rst       (rst),
        .e_valid   (e_valid),
        .e_is_br   (e_q.op == OP_BR),
        .e_delayed (e_q.delayed),
        .e_busy    (e_busy),
        .cond      (br_cond),
        .redirect  (redirect),
        .squash    (squash),
        .seq_err   (seq_err)
    );

    // decode-stage interlock on the final register of a load-multiple
    assign dep_stall = ldm_final && d_valid && (d_f.op == OP_ALU) &&
                       ((d_word[6:4] == ldm_last) || (d_word[2:0] == ldm_last));
    assign hold_front = e_busy || dep_stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            d_valid <= 1'b0;
            e_valid <= 1'b0;
            d_word  <= '0;
            d_pc    <= '0;
            e_q     <= '0;
            e_pc    <= '0;
        end else if (e_busy) begin
            d_valid <= d_valid;
        end else if (dep_stall) begin
            e_valid <= 1'b0;
        end else if (squash) begin
            d_valid <= 1'b0;
            e_valid <= 1'b0;
        end else begin
            e_valid <= d_valid;
            e_q     <= d_f;
            e_pc    <= d_pc;
            d_valid <= 1'b1;
            d_word  <= imem_data;
            d_pc    <= imem_addr;
        end
    end

    assign ret_valid = e_valid && !e_busy;
    assign ret_pc    = e_pc;
    assign wr_en     = ldm_we || (ret_valid && e_q.op == OP_ALU);
    assign wr_reg    = ldm_we ? ldm_reg : e_q.rd;

    // R1: reset empties the pipe and restarts fetch at zero
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && !ret_valid && !wr_en));

    // R3: a taken squashing branch leaves both younger stages empty
    p_squash_empty_r3: assert property (@(posedge clk) disable iff (rst)
        squash |=> (!d_valid && !e_valid));

    // R6: fetch and decode hold while a load-multiple occupies execute
    p_ldm_hold_r6: assert property (@(posedge clk) disable iff (rst)
        e_busy |=> ($stable(imem_addr) && $stable(d_pc)));

    // R8: a flagged branch retires but never redirects
    p_slot_branch_r8: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> (ret_valid && !redirect));

    // R7: the interlock bubble reaches execute on the next cycle
    p_dep_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        dep_stall |=> !e_valid);

endmodule

// File: tb/branch_pipe_ctrl_test.sv
`timescale 1ns/1ps
module branch_pipe_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [13:0] imem_data;
    logic        br_cond = 1'b0;
    logic        ret_valid, wr_en, redirect, seq_err;
    logic [7:0]  ret_pc;
    logic [2:0]  wr_reg;

    logic [13:0] mem [256];
    int          n_chk  = 0;
    int          n_fail = 0;
    logic        done   = 1'b0;

    always #10 clk = ~clk;

    assign imem_data = mem[imem_addr];

    branch_pipe_ctrl #(.ADDR_W(8)) uut (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .br_cond   (br_cond),
        .ret_valid (ret_valid),
        .ret_pc    (ret_pc),
        .wr_en     (wr_en),
        .wr_reg    (wr_reg),
        .redirect  (redirect),
        .seq_err   (seq_err)
    );

    // R9 encodings
    function automatic logic [13:0] w_alu(input logic [2:0] rd, input logic [2:0] a, input logic [2:0] b);
        return {2'b00, 1'b0, rd, 1'b0, a, 1'b0, b};
    endfunction
    function automatic logic [13:0] w_br(input logic dly, input logic [7:0] t);
        return {2'b01, dly, 3'b000, t};
    endfunction
    function automatic logic [13:0] w_ldm(input logic [7:0] lst);
        return {2'b10, 4'b0000, lst};
    endfunction
    localparam logic [13:0] W_NOP = 14'h3000;

    typedef struct packed {
        logic       cond;
        logic [7:0] addr;
        logic       rv;
        logic [7:0] pc;
        logic       we;
        logic [2:0] wr;
        logic       rd;
        logic       er;
    } row_t;

    // one row per cycle after reset release
    localparam row_t VEC [18] = '{
        '{1'b0,  8'd0, 1'b0,  8'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // R1 empty pipe
        '{1'b0,  8'd1, 1'b0,  8'd0, 1'b0, 3'd0, 1'b0, 1'b0},
        '{1'b0,  8'd2, 1'b1,  8'd0, 1'b1, 3'd1, 1'b0, 1'b0}, // R2 first retire in 3rd cycle
        '{1'b0,  8'd3, 1'b1,  8'd1, 1'b1, 3'd2, 1'b0, 1'b0},
        '{1'b1,  8'd4, 1'b1,  8'd2, 1'b0, 3'd0, 1'b1, 1'b0}, // R3 squashing branch taken
        '{1'b0,  8'd10,1'b0,  8'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // R3 bubble
        '{1'b0,  8'd11,1'b0,  8'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // R3 bubble
        '{1'b0,  8'd12,1'b0,  8'd0, 1'b1, 3'd1, 1'b0, 1'b0}, // R6 load r1
        '{1'b0,  8'd12,1'b0,  8'd0, 1'b1, 3'd3, 1'b0, 1'b0}, // R6 load r3
        '{1'b0,  8'd12,1'b1,  8'd10,1'b1, 3'd5, 1'b0, 1'b0}, // R6 load r5, retire
        '{1'b0,  8'd12,1'b0,  8'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // R7 bubble
        '{1'b0,  8'd13,1'b1,  8'd11,1'b1, 3'd6, 1'b0, 1'b0},
        '{1'b1,  8'd14,1'b1,  8'd12,1'b0, 3'd0, 1'b1, 1'b0}, // R4 delayed taken
        '{1'b0,  8'd20,1'b1,  8'd13,1'b1, 3'd1, 1'b0, 1'b0}, // R4 slot 1
        '{1'b1,  8'd21,1'b1,  8'd14,1'b0, 3'd0, 1'b0, 1'b1}, // R8 branch in slot 2
        '{1'b0,  8'd22,1'b1,  8'd20,1'b0, 3'd0, 1'b0, 1'b0}, // R5 not taken
        '{1'b0,  8'd23,1'b1,  8'd21,1'b1, 3'd2, 1'b0, 1'b0},
        '{1'b0,  8'd24,1'b1,  8'd22,1'b0, 3'd0, 1'b0, 1'b0}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        br_cond = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load_main();
        for (int i = 0; i < 256; i++) mem[i] = W_NOP;
        mem[0]  = w_alu(3'd1, 3'd2, 3'd3);
        mem[1]  = w_alu(3'd2, 3'd1, 3'd1);
        mem[2]  = w_br(1'b0, 8'd10);
        mem[3]  = w_alu(3'd4, 3'd0, 3'd0);
        mem[4]  = w_alu(3'd5, 3'd0, 3'd0);
        mem[10] = w_ldm(8'b0010_1010);
        mem[11] = w_alu(3'd6, 3'd5, 3'd0);
        mem[12] = w_br(1'b1, 8'd20);
        mem[13] = w_alu(3'd1, 3'd0, 3'd0);
        mem[14] = w_br(1'b1, 8'd30);
        mem[20] = w_br(1'b0, 8'd40);
        mem[21] = w_alu(3'd2, 3'd0, 3'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        load_main();
        do_reset();

        // vector walk over the main program
        for (int k = 0; k < 18; k++) begin
            if (k > 0) @(posedge clk);
            #1 br_cond = VEC[k].cond;
            @(negedge clk);
            chk("R2 fetch address", imem_addr, VEC[k].addr);
            chk("R2 retire valid", ret_valid, VEC[k].rv);
            if (VEC[k].rv) chk("R2 retire pc", ret_pc, VEC[k].pc);
            chk("R6 write enable", wr_en, VEC[k].we);
            if (VEC[k].we) chk("R6 write register", wr_reg, VEC[k].wr);
            chk("R3 redirect", redirect, VEC[k].rd);
            chk("R8 seq_err", seq_err, VEC[k].er);
        end

        // R1: reset in the middle of a run
        step();
        rst = 1'b1;
        step();
        @(negedge clk);
        chk("R1 addr after reset", imem_addr, 0);
        chk("R1 ret_valid after reset", ret_valid, 0);
        chk("R1 wr_en after reset", wr_en, 0);
        chk("R1 redirect after reset", redirect, 0);

        // R4 / R5: delayed branch not taken, stream stays sequential
        mem[2] = w_br(1'b1, 8'd10);
        do_reset();
        for (int k = 1; k <= 6; k++) begin
            step();
            @(negedge clk);
            if (k >= 2) begin
                chk("R4 retire valid", ret_valid, 1);
                chk("R4 retire pc", ret_pc, k - 2);
                chk("R5 no redirect", redirect, 0);
            end
        end
        chk("R5 sequential fetch", imem_addr, 6);

        // R6: empty list takes one cycle and writes nothing
        mem[0] = w_ldm(8'h00);
        mem[1] = w_alu(3'd3, 3'd0, 3'd0);
        do_reset();
        step(); step();
        @(negedge clk);
        chk("R6 empty list retires", ret_valid, 1);
        chk("R6 empty list pc", ret_pc, 0);
        chk("R6 empty list no write", wr_en, 0);
        step();
        @(negedge clk);
        chk("R6 follower pc", ret_pc, 1);
        chk("R6 follower write reg", wr_reg, 3);

        // R7: reading a non-final list register adds no bubble
        mem[0] = w_ldm(8'b0000_0110);
        mem[1] = w_alu(3'd7, 3'd1, 3'd1);
        do_reset();
        step(); step();
        @(negedge clk);
        chk("R7 first load reg", wr_reg, 1);
        chk("R7 busy no retire", ret_valid, 0);
        step();
        @(negedge clk);
        chk("R7 last load reg", wr_reg, 2);
        chk("R7 list retires", ret_pc, 0);
        step();
        @(negedge clk);
        chk("R7 no bubble retire", ret_valid, 1);
        chk("R7 no bubble pc", ret_pc, 1);
        chk("R7 follower write reg", wr_reg, 7);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule